// File: doc/BRIEF.md
# Servo Drive Pulse-Width Modulator

This block is the output stage of a one-axis digital position servo. Each cycle it takes the signed position error and the signed velocity feedback, and from them forms a drive command: twice the position error less the velocity, held to the signed 8-bit range. The magnitude of the command becomes the duty cycle of a fixed-period pulse train, and its polarity becomes a separate direction line. Together these two lines suit a unipolar motor driver stage.

The pulse period is 128 clock cycles. The block takes a new command only at the end of each period, so the pulse train never changes width partway through a period. When the latched duty reaches 90% or more of the period, a saturation warning tells the host that the servo is close to losing its ability to follow. An external overflow input blanks the pulse output at once, so that the drive can be shut off when the position error has been lost.

Top module: `servo_pwm_drive`

## Requirements
- R1: The drive command is `clamp(2*pos_err - vel_fb)`. Both inputs are two's-complement values. The clamp limits the result to the range -128..127.
- R2: The pulse period is 128 clock cycles. A period counter starts at 0 after reset and counts from 0 to 127. Within each period the pulse is high in the cycles whose counter value is below the latched duty, so the high cycles come first.
- R3: The duty is the magnitude of the command, clamped to 127 counts out of 128. A command of -128 therefore gives a duty of 127.
- R4: Duty, direction and saturation are sampled only at the clock edge that ends counter value 127. The new values take effect from counter value 0 of the next period. Input changes at any other time have no effect on those outputs.
- R5: `motor_dir` is 1 when the latched command is negative and 0 otherwise.
- R6: `sat_warn` is 1 for a whole period when the latched duty is at least 116 counts (90% of 128, rounded up), and 0 otherwise.
- R7: While `overflow` is 1, `pwm_out` is 0 in the same cycle. `overflow` does not change `motor_dir`, `sat_warn` or the period timing.
- R8: While `rst_n` is 0, `pwm_out`, `motor_dir` and `sat_warn` are 0, and the latched duty is 0.
- R9: A latched duty of 0 keeps `pwm_out` low for the whole period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_err | input | 8 | Signed position error |
| vel_fb | input | 8 | Signed velocity feedback |
| overflow | input | 1 | Servo overflow; blanks the pulse output |
| pwm_out | output | 1 | Pulse-width-modulated drive |
| motor_dir | output | 1 | Drive direction, 1 = negative command |
| sat_warn | output | 1 | Motor saturation warning |

## Verification
A new command is sampled at the clock edge that ends counter value 127. Its duty, direction and saturation show on the outputs from the very next cycle, one register stage after sampling. The overflow blanking acts in the same cycle it is applied, with no register in between. The bench runs its own period counter and latch model on each rising edge, and compares every output at the falling edge, where both the model and the design have settled. Scenario checks align to the model's period boundary: they count high cycles over exactly one latched period, and they change inputs partway through a period to show that the outputs keep their values until the boundary.

// File: rtl/servo_pwm_pkg.sv
package servo_pwm_pkg;

  // Saturating limit of a wide signed value to [lo, hi].
  function automatic int clamp_int(input int v, input int lo, input int hi);
    int r;
    r = v;
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    return r;
  endfunction

  // Magnitude of a signed value.
  function automatic int mag_int(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // Smallest duty count that is at least num/den of the period.
  function automatic int sat_threshold(input int period, input int num, input int den);
    return (period * num + den - 1) / den;
  endfunction

endpackage

// File: rtl/servo_drive_sum.sv
module servo_drive_sum #(
  parameter int CMD_W      = 8,
  parameter int GAIN_SHIFT = 1
) (
  input  logic signed [CMD_W-1:0] pos_err,
  input  logic signed [CMD_W-1:0] vel_fb,
  output logic signed [CMD_W-1:0] cmd
);
  import servo_pwm_pkg::*;

  localparam int CMD_MAX = (1 <<< (CMD_W-1)) - 1;
  localparam int CMD_MIN = -(1 <<< (CMD_W-1));

  int raw_sum;
  int lim_sum;

  always_comb begin
    raw_sum = (int'(pos_err) * (1 <<< GAIN_SHIFT)) - int'(vel_fb);
    lim_sum = clamp_int(raw_sum, CMD_MIN, CMD_MAX);
    cmd     = CMD_W'(lim_sum);
  end

endmodule

// File: rtl/servo_pwm_timebase.sv
module servo_pwm_timebase #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             period_end
);
  localparam logic [CNT_W-1:0] LAST = '1;

  assign period_end = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (period_end) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/servo_pwm_latch.sv
module servo_pwm_latch #(
  parameter int CMD_W   = 8,
  parameter int CNT_W   = 7,
  parameter int SAT_NUM = 9,
  parameter int SAT_DEN = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic signed [CMD_W-1:0] cmd,
  output logic [CNT_W-1:0]        duty,
  output logic                    neg,
  output logic                    sat
);
  import servo_pwm_pkg::*;

  localparam int PERIOD   = 1 << CNT_W;
  localparam int DUTY_MAX = PERIOD - 1;
  localparam int SAT_TH   = sat_threshold(PERIOD, SAT_NUM, SAT_DEN);

  int               mag_lim;
  logic [CNT_W-1:0] duty_d;
  logic             sat_d;

  always_comb begin
    mag_lim = clamp_int(mag_int(int'(cmd)), 0, DUTY_MAX);
    duty_d  = CNT_W'(mag_lim);
    sat_d   = (mag_lim >= SAT_TH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty <= '0;
      neg  <= 1'b0;
      sat  <= 1'b0;
    end else if (load) begin
      duty <= duty_d;
      neg  <= cmd[CMD_W-1];
      sat  <= sat_d;
    end
  end

endmodule

// File: rtl/servo_pwm_output.sv
module servo_pwm_output #(
  parameter int CNT_W = 7
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty,
  input  logic             blank,
  output logic             pulse
);
  logic in_on_phase;

  assign in_on_phase = (cnt < duty);
  assign pulse       = in_on_phase && !blank;

endmodule

// File: rtl/servo_pwm_drive.sv
module servo_pwm_drive #(
  parameter int CMD_W      = 8,
  parameter int CNT_W      = 7,
  parameter int GAIN_SHIFT = 1,
  parameter int SAT_NUM    = 9,
  parameter int SAT_DEN    = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [CMD_W-1:0] pos_err,
  input  logic signed [CMD_W-1:0] vel_fb,
  input  logic                    overflow,
  output logic                    pwm_out,
  output logic                    motor_dir,
  output logic                    sat_warn
);

  logic signed [CMD_W-1:0] cmd_w;
  logic [CNT_W-1:0]        cnt_w;
  logic                    boundary_w;
  logic [CNT_W-1:0]        duty_w;

  servo_drive_sum #(.CMD_W(CMD_W), .GAIN_SHIFT(GAIN_SHIFT)) sum_i (
    .pos_err (pos_err),
    .vel_fb  (vel_fb),
    .cmd     (cmd_w)
  );

  servo_pwm_timebase #(.CNT_W(CNT_W)) tb_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt        (cnt_w),
    .period_end (boundary_w)
  );

  servo_pwm_latch #(
    .CMD_W(CMD_W), .CNT_W(CNT_W), .SAT_NUM(SAT_NUM), .SAT_DEN(SAT_DEN)
  ) latch_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (boundary_w),
    .cmd   (cmd_w),
    .duty  (duty_w),
    .neg   (motor_dir),
    .sat   (sat_warn)
  );

  servo_pwm_output #(.CNT_W(CNT_W)) out_i (
    .cnt   (cnt_w),
    .duty  (duty_w),
    .blank (overflow),
    .pulse (pwm_out)
  );

endmodule

// File: rtl/servo_pwm_drive_chk.sv
module servo_pwm_drive_chk #(
  parameter int CNT_W   = 7,
  parameter int SAT_NUM = 9,
  parameter int SAT_DEN = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             overflow,
  input logic             pwm_out,
  input logic             motor_dir,
  input logic             sat_warn,
  input logic [CNT_W-1:0] cnt_w,
  input logic [CNT_W-1:0] duty_w,
  input logic             boundary_w
);
  import servo_pwm_pkg::*;

  localparam int PERIOD = 1 << CNT_W;
  localparam logic [CNT_W-1:0] SAT_TH = CNT_W'(sat_threshold(PERIOD, SAT_NUM, SAT_DEN));

  // R2: counter restarts after the last count and otherwise steps by one
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_w |=> (cnt_w == '0));
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary_w |=> (cnt_w == CNT_W'($past(cnt_w) + 1'b1)));

  // R4: duty changes only across a period boundary
  a_r4_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary_w |=> $stable(duty_w));

  // R5: direction changes only across a period boundary
  a_r5_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary_w |=> $stable(motor_dir));

  // R6: warning agrees with the latched duty and holds for the period
  a_r6_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
    sat_warn |-> (duty_w >= SAT_TH));
  a_r6_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
    !sat_warn |-> (duty_w < SAT_TH));
  a_r6_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary_w |=> $stable(sat_warn));

  // R7: overflow blanks the pulse
  a_r7_blank: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> !pwm_out);

  // R9: zero duty never pulses
  a_r9_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_w == '0) |-> !pwm_out);

endmodule

bind servo_pwm_drive servo_pwm_drive_chk #(
  .CNT_W(CNT_W), .SAT_NUM(SAT_NUM), .SAT_DEN(SAT_DEN)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .overflow   (overflow),
  .pwm_out    (pwm_out),
  .motor_dir  (motor_dir),
  .sat_warn   (sat_warn),
  .cnt_w      (cnt_w),
  .duty_w     (duty_w),
  .boundary_w (boundary_w)
);

// File: tb/servo_pwm_drive_tb.sv
`timescale 1ns/1ps
module servo_pwm_drive_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [7:0] pos_err = '0;
  logic signed [7:0] vel_fb = '0;
  logic overflow = 1'b0;
  logic pwm_out, motor_dir, sat_warn;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  servo_pwm_drive dut_i (
    .clk(clk), .rst_n(rst_n), .pos_err(pos_err), .vel_fb(vel_fb),
    .overflow(overflow), .pwm_out(pwm_out), .motor_dir(motor_dir),
    .sat_warn(sat_warn)
  );

  // Behavioural reference model
  int m_cnt = 0, m_duty = 0;
  bit m_neg = 0, m_sat = 0;

  function automatic int ref_cmd(int p, int v);
    int c;
    c = p + p - v;
    if (c > 127) c = 127;
    else if (c < -128) c = -128;
    return c;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_duty = 0; m_neg = 0; m_sat = 0;
    end else if (m_cnt == 127) begin
      int c, mg;
      c = ref_cmd(int'(pos_err), int'(vel_fb));
      mg = (c < 0) ? -c : c;
      if (mg > 127) mg = 127;
      m_duty = mg;
      m_neg = (c < 0);
      m_sat = (mg * 10 >= 128 * 9);
      m_cnt = 0;
    end else begin
      m_cnt = m_cnt + 1;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model (R2/R3/R4 pulse, R5 dir, R6 sat, R7 blank)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit ep;
      ep = !overflow && (m_cnt < m_duty);
      check(pwm_out === ep, "R2_R3_R7 pwm_out", int'(pwm_out), int'(ep));
      check(motor_dir === m_neg, "R4_R5 motor_dir", int'(motor_dir), int'(m_neg));
      check(sat_warn === m_sat, "R4_R6 sat_warn", int'(sat_warn), int'(m_sat));
    end
  end

  task automatic to_last();
    @(negedge clk);
    while (m_cnt != 127) @(negedge clk);
  endtask

  task automatic measure(output int highs);
    to_last();
    highs = 0;
    repeat (128) begin
      @(negedge clk);
      highs += int'(pwm_out);
    end
  endtask

  task automatic run(int p, int v, int exp_hi, bit exp_dir, bit exp_sat, string req);
    int h;
    pos_err = 8'(p);
    vel_fb = 8'(v);
    measure(h);
    check(h == exp_hi, {req, " high count"}, h, exp_hi);
    check(motor_dir == exp_dir, {req, " dir"}, int'(motor_dir), int'(exp_dir));
    check(sat_warn == exp_sat, {req, " sat"}, int'(sat_warn), int'(exp_sat));
  endtask

  initial begin
    int h;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(pwm_out == 0 && motor_dir == 0 && sat_warn == 0, "R8 reset outputs",
          int'({pwm_out, motor_dir, sat_warn}), 0);
    rst_n = 1'b1;
    // R9: zero command after reset and explicitly
    run(0, 0, 0, 0, 0, "R9 zero");
    run(10, 20, 0, 0, 0, "R9 cancel");
    // R1: sum with gain
    run(40, -10, 90, 0, 0, "R1 sum");
    run(-20, 10, 50, 1, 0, "R1_R5 neg");
    // R6 threshold edges
    run(58, 0, 116, 0, 1, "R6 at 116");
    run(58, 1, 115, 0, 0, "R6 at 115");
    run(-58, 0, 116, 1, 1, "R6_R5 neg 116");
    // R1/R3 saturation of the sum and of the magnitude
    run(127, -128, 127, 0, 1, "R1_R3 pos clamp");
    run(-128, 127, 127, 1, 1, "R1_R3 neg clamp");
    run(-64, 0, 127, 1, 1, "R3 cmd -128");
    run(0, -1, 1, 0, 0, "R2 duty 1");
    // R4: change mid-period, latched values hold
    run(30, 0, 60, 0, 0, "R4 base");
    repeat (20) @(negedge clk);
    pos_err = -8'sd60; vel_fb = 8'sd0;
    repeat (5) @(negedge clk);
    check(motor_dir == 0, "R4 dir held", int'(motor_dir), 0);
    check(sat_warn == 0, "R4 sat held", int'(sat_warn), 0);
    measure(h);
    check(h == 120, "R4 new period count", h, 120);
    check(motor_dir == 1 && sat_warn == 1, "R4 new period flags",
          int'({motor_dir, sat_warn}), 3);
    // R7: overflow blanks pulses but keeps flags
    pos_err = -8'sd60;
    overflow = 1'b1;
    measure(h);
    check(h == 0, "R7 blanked count", h, 0);
    check(motor_dir == 1 && sat_warn == 1, "R7 flags kept", int'({motor_dir, sat_warn}), 3);
    overflow = 1'b0;
    @(negedge clk);
    check(m_cnt == 1 || m_cnt == 0 ? 1'b1 : (pwm_out == 1), "R7 pulse returns", int'(pwm_out), 1);
    // R8: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(pwm_out == 0 && motor_dir == 0 && sat_warn == 0, "R8 async reset",
          int'({pwm_out, motor_dir, sat_warn}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    pos_err = '0;
    run(0, 0, 0, 0, 0, "R8_R9 after reset");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule